// File: doc/BRIEF.md
# Dual-Lane Logarithm Table Front End

This block is the table-lookup stage for two independent single-precision logarithm pipelines. Each lane takes a 32-bit IEEE-754 single-precision word and a valid flag. From the exponent field it forms a folded index into a half-size exponent table. From the top mantissa bits it forms an index into the mantissa table. It returns both single-precision operands together with a delayed valid flag. The multiply by the log-of-two constant and the final addition happen downstream and are outside this block.

Each table is stored once, as a read-only memory with two read ports, and each lane owns one port of each table. This gives two results per clock while holding only one copy of the table storage. The instantiator supplies the table contents as parameter arrays. The mantissa table depth is a power-of-two parameter from 512 to 32768.

Top module: `lgfe_dual_front`

## Requirements
- R1: Each lane has a fixed latency of two clock edges. A word sampled with its valid flag at rising edge k appears on that lane's outputs after rising edge k+1, and the valid output is high only in that cycle.
- R2: The exponent operand is built from the 8-bit exponent field e. When e[7] is 0 the exponent table index is e[6:0]; when e[7] is 1 it is the low 7 bits of 254−e. Bits 30:0 of the operand are bits 30:0 of the exponent table entry at that index, and bit 31 is the inverse of e[7].
- R3: The mantissa operand is the mantissa table entry indexed by the top log2(MAN_DEPTH) bits of the 23-bit fraction (bits 22:14 for 512 entries). All lower fraction bits have no effect on it.
- R4: The two lanes are independent. A lane's outputs depend only on that lane's own inputs.
- R5: When both lanes present words with the same bits 30:0 in the same cycle, both lanes return identical operands in the same cycle, with no stall.
- R6: There is no backpressure. A lane whose valid input is low still advances its pipeline, and its valid output is low two edges later.
- R7: A synchronous active-high reset clears both valid outputs on the edge where it is sampled.
- R8: Each lane accepts a new word on every clock, so back-to-back words produce back-to-back results.
- R9: The input sign bit (bit 31) has no effect on either operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_vld | input | 1 | Lane A input valid |
| a_val | input | 32 | Lane A single-precision input |
| b_vld | input | 1 | Lane B input valid |
| b_val | input | 32 | Lane B single-precision input |
| a_out_vld | output | 1 | Lane A result valid |
| a_exp_op | output | 32 | Lane A exponent operand |
| a_man_op | output | 32 | Lane A mantissa operand |
| b_out_vld | output | 1 | Lane B result valid |
| b_exp_op | output | 32 | Lane B exponent operand |
| b_man_op | output | 32 | Lane B mantissa operand |

## Verification
The checker assumes reset is held for at least two edges, so that the two-deep history it compares against always comes from after reset. It also assumes that input words carry no unknown bits while their valid flag is high. The bench holds reset for three edges and drives every input, including the data on invalid cycles, to known values at the falling edge. Special values such as exponent 0 and exponent 255 are legal inputs here, because the block only looks up table entries and does not classify them.

// File: rtl/lgfe_pkg.sv
package lgfe_pkg;

    localparam int SP_W       = 32;
    localparam int EXP_W      = 8;
    localparam int FRAC_W     = 23;
    localparam int NLANES     = 2;
    localparam int ETAB_AW    = EXP_W - 1;
    localparam int ETAB_DEPTH = 1 << ETAB_AW;

    typedef logic [SP_W-1:0] word_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } sp_t;

    typedef struct packed {
        logic               vld;
        logic               neg;
        logic [ETAB_AW-1:0] eidx;
    } ereq_t;

    typedef struct packed {
        logic  vld;
        logic  neg;
    } tail_t;

    // Upper half of exponent codes mirrors onto the lower half: idx = 254 - e
    function automatic logic [ETAB_AW-1:0] fold_exp(input logic [EXP_W-1:0] e);
        logic [EXP_W-1:0] mirrored;
        mirrored = (~e) - {{(EXP_W-1){1'b0}}, 1'b1};
        return e[EXP_W-1] ? mirrored[ETAB_AW-1:0] : e[ETAB_AW-1:0];
    endfunction

    function automatic word_t with_sign(input word_t w, input logic s);
        return {s, w[SP_W-2:0]};
    endfunction

endpackage

// File: rtl/lgfe_dp_rom.sv
module lgfe_dp_rom #(
    parameter int W     = 32,
    parameter int DEPTH = 128,
    parameter int NP    = 2,
    parameter int AW    = $clog2(DEPTH),
    parameter logic [W-1:0] CONTENT [DEPTH] = '{default: '0}
) (
    input  logic                  clk,
    input  logic [NP-1:0][AW-1:0] addr,
    output logic [NP-1:0][W-1:0]  data
);

    // One registered read port per lane over a single shared array
    for (genvar p = 0; p < NP; p++) begin : g_port
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            q <= CONTENT[addr[p]];
        end
        assign data[p] = q;
    end

endmodule

// File: rtl/lgfe_lane.sv
module lgfe_lane
    import lgfe_pkg::*;
#(
    parameter int MAN_AW = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld,
    input  word_t              in_val,
    output logic [ETAB_AW-1:0] eidx,
    output logic [MAN_AW-1:0]  midx,
    input  word_t              e_rd,
    input  word_t              m_rd,
    output logic               out_vld,
    output word_t              out_exp,
    output word_t              out_man
);

    sp_t                x;
    ereq_t              s1;
    logic [MAN_AW-1:0]  s1_midx;
    tail_t              s2;

    assign x = sp_t'(in_val);

    // Stage 1: form table indices; data fields advance regardless of valid
    always_ff @(posedge clk) begin
        if (rst) begin
            s1.vld <= 1'b0;
        end else begin
            s1.vld <= in_vld;
        end
        s1.neg  <= ~x.expo[EXP_W-1];
        s1.eidx <= fold_exp(x.expo);
        s1_midx <= x.frac[FRAC_W-1 -: MAN_AW];
    end

    assign eidx = s1.eidx;
    assign midx = s1_midx;

    // Stage 2: align control with the registered table read
    always_ff @(posedge clk) begin
        if (rst) begin
            s2.vld <= 1'b0;
        end else begin
            s2.vld <= s1.vld;
        end
        s2.neg <= s1.neg;
    end

    assign out_vld = s2.vld;
    assign out_exp = with_sign(e_rd, s2.neg);
    assign out_man = m_rd;

endmodule

// File: rtl/lgfe_dual_front.sv
module lgfe_dual_front
    import lgfe_pkg::*;
#(
    parameter int    MAN_DEPTH = 512,
    parameter int    MAN_AW    = $clog2(MAN_DEPTH),
    parameter word_t EXP_TABLE [ETAB_DEPTH] = '{default: '0},
    parameter word_t MAN_TABLE [MAN_DEPTH]  = '{default: '0}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        a_vld,
    input  logic [31:0] a_val,
    input  logic        b_vld,
    input  logic [31:0] b_val,
    output logic        a_out_vld,
    output logic [31:0] a_exp_op,
    output logic [31:0] a_man_op,
    output logic        b_out_vld,
    output logic [31:0] b_exp_op,
    output logic [31:0] b_man_op
);

    logic  [NLANES-1:0]              ln_vld_in;
    word_t [NLANES-1:0]              ln_val_in;
    logic  [NLANES-1:0][ETAB_AW-1:0] e_addr;
    logic  [NLANES-1:0][MAN_AW-1:0]  m_addr;
    word_t [NLANES-1:0]              e_data;
    word_t [NLANES-1:0]              m_data;
    logic  [NLANES-1:0]              ln_vld_out;
    word_t [NLANES-1:0]              ln_exp_out;
    word_t [NLANES-1:0]              ln_man_out;

    assign ln_vld_in = {b_vld, a_vld};
    assign ln_val_in = {b_val, a_val};

    lgfe_dp_rom #(
        .W       (SP_W),
        .DEPTH   (ETAB_DEPTH),
        .NP      (NLANES),
        .AW      (ETAB_AW),
        .CONTENT (EXP_TABLE)
    ) u_exp_rom (
        .clk  (clk),
        .addr (e_addr),
        .data (e_data)
    );

    lgfe_dp_rom #(
        .W       (SP_W),
        .DEPTH   (MAN_DEPTH),
        .NP      (NLANES),
        .AW      (MAN_AW),
        .CONTENT (MAN_TABLE)
    ) u_man_rom (
        .clk  (clk),
        .addr (m_addr),
        .data (m_data)
    );

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        lgfe_lane #(
            .MAN_AW (MAN_AW)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (ln_vld_in[l]),
            .in_val  (ln_val_in[l]),
            .eidx    (e_addr[l]),
            .midx    (m_addr[l]),
            .e_rd    (e_data[l]),
            .m_rd    (m_data[l]),
            .out_vld (ln_vld_out[l]),
            .out_exp (ln_exp_out[l]),
            .out_man (ln_man_out[l])
        );
    end

    assign a_out_vld = ln_vld_out[0];
    assign a_exp_op  = ln_exp_out[0];
    assign a_man_op  = ln_man_out[0];
    assign b_out_vld = ln_vld_out[1];
    assign b_exp_op  = ln_exp_out[1];
    assign b_man_op  = ln_man_out[1];

endmodule

// File: rtl/lgfe_dual_front_chk.sv
module lgfe_dual_front_chk (
    input logic        clk,
    input logic        rst,
    input logic        a_vld,
    input logic [31:0] a_val,
    input logic        b_vld,
    input logic [31:0] b_val,
    input logic        a_out_vld,
    input logic [31:0] a_exp_op,
    input logic [31:0] a_man_op,
    input logic        b_out_vld,
    input logic [31:0] b_exp_op,
    input logic [31:0] b_man_op
);

    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q) begin
            AST_RST_CLEARS: assert (!a_out_vld && !b_out_vld); // R7
        end
    end

    AST_VLD_ALIGN_A: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (a_out_vld == $past(a_vld, 2))); // R6

    AST_VLD_ALIGN_B: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (b_out_vld == $past(b_vld, 2))); // R6

    AST_SIGN_FROM_EXP_A: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && a_out_vld) |-> (a_exp_op[31] == !$past(a_val[30], 2))); // R2

    AST_SIGN_FROM_EXP_B: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && b_out_vld) |-> (b_exp_op[31] == !$past(b_val[30], 2))); // R2

    AST_SAME_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && a_out_vld && b_out_vld &&
         $past(a_val[30:0] == b_val[30:0], 2))
        |-> (a_exp_op == b_exp_op && a_man_op == b_man_op)); // R5

endmodule

bind lgfe_dual_front lgfe_dual_front_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_vld     (a_vld),
    .a_val     (a_val),
    .b_vld     (b_vld),
    .b_val     (b_val),
    .a_out_vld (a_out_vld),
    .a_exp_op  (a_exp_op),
    .a_man_op  (a_man_op),
    .b_out_vld (b_out_vld),
    .b_exp_op  (b_exp_op),
    .b_man_op  (b_man_op)
);

// File: tb/lgfe_dual_front_test.sv
module lgfe_dual_front_test;

    localparam int MD = 512;
    localparam int ED = 128;

    typedef logic [31:0] et_t [ED];
    typedef logic [31:0] mt_t [MD];

    function automatic et_t build_et();
        et_t t;
        for (int i = 0; i < ED; i++)
            t[i] = {i[0], 8'(i + 3), 23'(i * 1237 + 11)};
        return t;
    endfunction

    function automatic mt_t build_mt();
        mt_t t;
        for (int i = 0; i < MD; i++)
            t[i] = 32'hA5000000 ^ (32'(i) * 32'h9E3779B1);
        return t;
    endfunction

    localparam et_t ET = build_et();
    localparam mt_t MT = build_mt();

    typedef struct packed {
        logic        av;
        logic [31:0] a;
        logic        bv;
        logic [31:0] b;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h3F800000, 1'b1, 32'h40000000},  // R2 exp 127 / 128
        '{1'b1, 32'h00000000, 1'b1, 32'h7F7FFFFF},  // R2 exp 0 / 254
        '{1'b1, 32'h7F800000, 1'b1, 32'hBF800000},  // R2 exp 255, R9 sign set
        '{1'b1, 32'h3F800000, 1'b1, 32'hBF800000},  // R5 same addr apart from sign, R9
        '{1'b1, 32'h3FC00000, 1'b1, 32'h3FC00000},  // R5 identical words
        '{1'b1, 32'h3FC03FFF, 1'b1, 32'h3FC00001},  // R3 low fraction bits
        '{1'b0, 32'h12345678, 1'b1, 32'h40490FDB},  // R6 lane A idle
        '{1'b1, 32'h40490FDB, 1'b0, 32'h00000001},  // R6 lane B idle
        '{1'b0, 32'h00000000, 1'b0, 32'h00000000},  // R6 both idle
        '{1'b1, 32'h3E000000, 1'b1, 32'h41200000},  // R4 base
        '{1'b1, 32'h3E000000, 1'b1, 32'h44FA0000},  // R4 B differs
        '{1'b1, 32'h3E000000, 1'b1, 32'h00800000},  // R4 B differs again
        '{1'b1, 32'h4B7FC000, 1'b1, 32'h3F7FC000},  // R3 top index
        '{1'b1, 32'h0FFFC000, 1'b1, 32'h70000000}   // R8 back-to-back tail
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_vld = 1'b0, b_vld = 1'b0;
    logic [31:0] a_val = '0, b_val = '0;
    logic        a_out_vld, b_out_vld;
    logic [31:0] a_exp_op, a_man_op, b_exp_op, b_man_op;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lgfe_dual_front #(
        .MAN_DEPTH (MD),
        .EXP_TABLE (ET),
        .MAN_TABLE (MT)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .a_vld     (a_vld),
        .a_val     (a_val),
        .b_vld     (b_vld),
        .b_val     (b_val),
        .a_out_vld (a_out_vld),
        .a_exp_op  (a_exp_op),
        .a_man_op  (a_man_op),
        .b_out_vld (b_out_vld),
        .b_exp_op  (b_exp_op),
        .b_man_op  (b_man_op)
    );

    function automatic logic [31:0] exp_of(input logic [31:0] x);
        logic [7:0] e;
        logic [7:0] m;
        logic [6:0] idx;
        e   = x[30:23];
        m   = 8'd254 - e;
        idx = e[7] ? m[6:0] : e[6:0];
        return {~e[7], ET[idx][30:0]};
    endfunction

    function automatic logic [31:0] man_of(input logic [31:0] x);
        return MT[x[22:14]];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_vec(input vec_t v);
        chk("R6 lane A valid", 32'(a_out_vld), 32'(v.av));
        chk("R6 lane B valid", 32'(b_out_vld), 32'(v.bv));
        if (v.av) begin
            chk("R2 lane A exponent operand", a_exp_op, exp_of(v.a));
            chk("R3 lane A mantissa operand", a_man_op, man_of(v.a));
        end
        if (v.bv) begin
            chk("R2 lane B exponent operand", b_exp_op, exp_of(v.b));
            chk("R3 lane B mantissa operand", b_man_op, man_of(v.b));
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset valid A", 32'(a_out_vld), 32'd0);
        chk("R7 reset valid B", 32'(b_out_vld), 32'd0);
        rst = 1'b0;

        // Vector walk, one word per lane per clock (R8)
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) check_vec(VEC[i-2]);
            if (i < NV) begin
                a_vld = VEC[i].av; a_val = VEC[i].a;
                b_vld = VEC[i].bv; b_val = VEC[i].b;
            end else begin
                a_vld = 1'b0; b_vld = 1'b0; a_val = '0; b_val = '0;
            end
            @(negedge clk);
        end

        // R5 explicit cross-lane equality at the same address
        a_vld = 1'b1; a_val = 32'h3FA00000;
        b_vld = 1'b1; b_val = 32'hBFA00000;
        @(negedge clk);
        a_vld = 1'b0; b_vld = 1'b0;
        @(negedge clk);
        chk("R5 shared exponent operand", b_exp_op, a_exp_op);
        chk("R5 shared mantissa operand", b_man_op, a_man_op);

        // R1 single pulse latency
        a_vld = 1'b1; a_val = 32'h42280000;
        @(negedge clk);
        a_vld = 1'b0;
        chk("R1 not valid after one edge", 32'(a_out_vld), 32'd0);
        @(negedge clk);
        chk("R1 valid after two edges", 32'(a_out_vld), 32'd1);
        chk("R1 data after two edges", a_exp_op, exp_of(32'h42280000));
        @(negedge clk);
        chk("R1 valid drops after one cycle", 32'(a_out_vld), 32'd0);

        // R7 reset while words in flight
        a_vld = 1'b1; b_vld = 1'b1; a_val = 32'h3F000000; b_val = 32'h3F000000;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R7 reset clears A in flight", 32'(a_out_vld), 32'd0);
        chk("R7 reset clears B in flight", 32'(b_out_vld), 32'd0);
        rst = 1'b0;
        a_vld = 1'b0; b_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 no stale valid A", 32'(a_out_vld), 32'd0);
        chk("R7 no stale valid B", 32'(b_out_vld), 32'd0);

        finish_run();
    end

endmodule